// File: doc/BRIEF.md
# Tagged Sample Output Queue with Self-Starting Serial Transmitter

This block sits between a decimation filter and a telemetry link. Each time the filter presents a 24-bit sample with a one-cycle valid pulse, the block joins it with an 8-bit status byte to form a 32-bit entry. Seven status bits come straight from an input port. The top bit is a time-break marker. An asynchronous timing strobe sets a sticky latch, and the next accepted sample carries that latch.

Entries wait in an eight-deep queue. Whenever the queue is not empty and the link is idle, the block begins a serial frame on its own. It does not wait for a request from the receiver. The frame comes with a framing strobe, a bit clock at half the system clock, and one data line. A format input chooses between two frame lengths: 24 data bits only, or 32 bits with the status byte in front. If a sample arrives while the queue is full, the sample is lost and a sticky overflow indicator is raised.

Top module: `tagged_sample_fifo`

## Requirements
- R1: With `fmt_long`=1, a frame carries 32 bits, MSB first: entry bit 31 is the time-break flag, bits 30:24 are `smp_status`, and bits 23:0 are `smp_data`.
- R2: With `fmt_long`=0, a frame carries only the 24 data bits, MSB first. `fmt_long` is taken at the start of each frame.
- R3: A frame starts by itself whenever the queue holds an entry and the link is idle. `ser_frame` stays high for exactly 2×N system clocks, where N is 24 or 32.
- R4: Each bit takes two system clocks, with `ser_clk` low in the first and high in the second. `ser_dout` is stable over both clocks and is sampled on the rising edge of `ser_clk`. Outside a frame, `ser_clk` is low.
- R5: Between two frames, `ser_frame` stays low for at least two system clocks, which is one bit-clock period.
- R6: The queue holds eight entries and delivers them in arrival order. One more entry can be in flight on the link.
- R7: A sample that arrives while the queue is full is dropped, and `ovf_flag` is set. `ovf_flag` stays set until `ovf_clear` is pulsed. A new overflow in the same cycle as the clear wins over the clear.
- R8: A rising edge on `tb_strobe`, after a two-stage synchronizer, sets bit 31 of the next sample that arrives with a valid pulse. The latch is cleared at that sample. A strobe held high counts only once.
- R9: A write and a read in the same cycle leave the occupancy unchanged. No entry is lost or repeated.
- R10: After reset, `ser_frame`, `ser_clk`, `ser_dout` and `ovf_flag` are all 0, and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 24 | Filtered sample value |
| smp_status | input | 7 | Status bits 30:24 of the entry |
| tb_strobe | input | 1 | Asynchronous time-break strobe |
| fmt_long | input | 1 | 1: 32-bit frames, 0: 24-bit frames |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| ser_clk | output | 1 | Bit clock, half the system clock, only during a frame |
| ser_frame | output | 1 | High for the whole frame |
| ser_dout | output | 1 | Serial data, MSB first |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
An occupancy count that drifts away from the real contents shows up in one of two ways. Frames may repeat stale words or skip words, which is visible at the first frame after the error. Or the overflow flag may rise too early or too late in a burst of samples. A time-break latch that is stuck or cleared at the wrong moment shows as a wrong top bit in the very next frame. A bit counter or phase error changes the frame length or the bit-clock shape within that same frame. The bench therefore compares every frame word, its bit count, its strobe length and the idle gap that follows, all against values it computes itself.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
   typedef enum logic {
      FMT_SHORT = 1'b0,
      FMT_LONG  = 1'b1
   } frame_fmt_e;

   localparam int unsigned TSF_DATA_W = 24;
   localparam int unsigned TSF_STAT_W = 8;
endpackage

// File: rtl/tsf_tb_capture.sv
module tsf_tb_capture #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_async,
   input  logic consume,
   output logic flag
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tsf_tb_capture: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   hold_q;
   logic                   rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_async};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

   // The flag includes an edge that lands in the same cycle as the consuming sample.
   assign flag = hold_q | rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q <= 1'b0;
      else if (consume) hold_q <= 1'b0;
      else if (rise)    hold_q <= 1'b1;
   end

   // R8
   tb_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !consume) |=> hold_q);
   // R8
   tb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      consume |=> !hold_q);
endmodule

// File: rtl/tsf_fifo.sv
module tsf_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty,
   output logic             full
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("tsf_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tsf_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [AW-1:0]    wptr_nx, rptr_nx;
   logic [CW-1:0]    count;

   generate
      if (POW2) begin : g_wrap_natural
         assign wptr_nx = wptr + AW'(1);
         assign rptr_nx = rptr + AW'(1);
      end else begin : g_wrap_compare
         assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
         assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (wr_en) wptr <= wptr_nx;
         if (rd_en) rptr <= rptr_nx;
         unique case ({wr_en, rd_en})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   assign rd_data = mem[rptr];
   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (count != '0));
   // R9
   both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en) |=> (count == $past(count)));
   // R7
   full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !wr_en);
endmodule

// File: rtl/tsf_serializer.sv
module tsf_serializer
   import tsf_pkg::*;
#(
   parameter int unsigned DATA_W    = 24,
   parameter int unsigned STAT_W    = 8,
   parameter int unsigned IDLE_CLKS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     avail,
   input  logic [DATA_W+STAT_W-1:0] entry,
   input  logic                     fmt_long,
   output logic                     take,
   output logic                     ser_clk,
   output logic                     ser_frame,
   output logic                     ser_dout
);
   localparam int unsigned FW = DATA_W + STAT_W;
   localparam int unsigned CW = $clog2(FW);
   localparam int unsigned GW = $clog2(IDLE_CLKS + 1);

   generate
      if (IDLE_CLKS < 2) begin : g_bad_idle
         $error("tsf_serializer: IDLE_CLKS must cover one bit-clock period");
      end
   endgenerate

   frame_fmt_e    fmt;
   logic          busy, phase;
   logic [CW-1:0] bits_left;
   logic [FW-1:0] shreg;
   logic [GW-1:0] gap;

   assign fmt  = frame_fmt_e'(fmt_long);
   assign take = !busy && (gap == '0) && avail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         phase     <= 1'b0;
         bits_left <= '0;
         shreg     <= '0;
         gap       <= '0;
      end else if (!busy) begin
         if (gap != '0) begin
            gap <= gap - GW'(1);
         end else if (take) begin
            busy  <= 1'b1;
            phase <= 1'b0;
            if (fmt == FMT_LONG) begin
               bits_left <= CW'(FW - 1);
               shreg     <= entry;
            end else begin
               bits_left <= CW'(DATA_W - 1);
               shreg     <= entry << STAT_W;
            end
         end
      end else begin
         phase <= ~phase;
         if (phase) begin
            if (bits_left == '0) begin
               busy <= 1'b0;
               gap  <= GW'(IDLE_CLKS - 1);
            end else begin
               bits_left <= bits_left - CW'(1);
               shreg     <= shreg << 1;
            end
         end
      end
   end

   assign ser_frame = busy;
   assign ser_clk   = busy & phase;
   assign ser_dout  = busy & shreg[FW-1];

   // R5
   idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_frame) |=> !ser_frame);
   // R4
   bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_frame && !ser_clk) |=> (ser_clk && $stable(ser_dout)));
   // R3
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_frame) |-> !ser_clk);
endmodule

// File: rtl/tagged_sample_fifo.sv
module tagged_sample_fifo
   import tsf_pkg::*;
#(
   parameter int unsigned DATA_W      = TSF_DATA_W,
   parameter int unsigned STAT_W      = TSF_STAT_W,
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IDLE_CLKS   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [STAT_W-2:0] smp_status,
   input  logic              tb_strobe,
   input  logic              fmt_long,
   input  logic              ovf_clear,
   output logic              ser_clk,
   output logic              ser_frame,
   output logic              ser_dout,
   output logic              ovf_flag
);
   localparam int unsigned FW = DATA_W + STAT_W;

   generate
      if (STAT_W < 2) begin : g_bad_stat
         $error("tagged_sample_fifo: STAT_W must be at least 2");
      end
   endgenerate

   logic          tb_flag;
   logic [FW-1:0] wr_entry, rd_entry;
   logic          q_empty, q_full, q_wr, q_rd;
   logic          ovf_q;

   tsf_tb_capture #(.SYNC_STAGES(SYNC_STAGES)) u_tb (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe_async(tb_strobe),
      .consume     (smp_valid),
      .flag        (tb_flag)
   );

   assign wr_entry = {tb_flag, smp_status, smp_data};
   assign q_wr     = smp_valid & ~q_full;

   tsf_fifo #(.WIDTH(FW), .DEPTH(DEPTH)) u_queue (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (q_wr),
      .wr_data(wr_entry),
      .rd_en  (q_rd),
      .rd_data(rd_entry),
      .empty  (q_empty),
      .full   (q_full)
   );

   tsf_serializer #(
      .DATA_W   (DATA_W),
      .STAT_W   (STAT_W),
      .IDLE_CLKS(IDLE_CLKS)
   ) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .avail    (~q_empty),
      .entry    (rd_entry),
      .fmt_long (fmt_long),
      .take     (q_rd),
      .ser_clk  (ser_clk),
      .ser_frame(ser_frame),
      .ser_dout (ser_dout)
   );

   // A new overflow wins over a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ovf_q <= 1'b0;
      else if (smp_valid && q_full)  ovf_q <= 1'b1;
      else if (ovf_clear)            ovf_q <= 1'b0;
   end

   assign ovf_flag = ovf_q;

   // R7
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && q_full) |=> ovf_flag);
   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clear) |=> ovf_flag);
   // R3
   auto_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_frame) |-> $past(!q_empty));
endmodule

// File: tb/tagged_sample_fifo_test.sv
module tagged_sample_fifo_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [23:0] smp_data = '0;
   logic [6:0]  smp_status = '0;
   logic        tb_strobe = 1'b0;
   logic        fmt_long = 1'b1;
   logic        ovf_clear = 1'b0;
   logic        ser_clk, ser_frame, ser_dout, ovf_flag;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   tagged_sample_fifo uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_status(smp_status), .tb_strobe(tb_strobe), .fmt_long(fmt_long),
      .ovf_clear(ovf_clear), .ser_clk(ser_clk), .ser_frame(ser_frame),
      .ser_dout(ser_dout), .ovf_flag(ovf_flag)
   );

   always #2.5 clk = ~clk;

   // frame monitor
   logic [31:0] got_w [64];
   int          got_b [64];
   int          got_l [64];
   int          got_n = 0;
   logic [31:0] cap = '0;
   int          nb = 0, flen = 0, idle = 0;
   int          gap_bad = 0, clk_bad = 0;
   logic        prev_frame = 1'b0;

   always @(negedge clk) begin
      cycles++;
      if (!ser_frame && ser_clk) clk_bad++;
      if (ser_frame) begin
         if (!prev_frame) begin
            if (got_n > 0 && idle < 2) gap_bad++;
            cap = '0; nb = 0; flen = 0;
         end
         flen++;
         if (ser_clk) begin
            cap = {cap[30:0], ser_dout};
            nb++;
         end
      end else begin
         if (prev_frame && got_n < 64) begin
            got_w[got_n] = cap; got_b[got_n] = nb; got_l[got_n] = flen;
            got_n++;
         end
         if (prev_frame) idle = 0;
         idle++;
      end
      prev_frame = ser_frame;
   end

   // expected frames
   logic [31:0] exp_w [64];
   int          exp_b [64];
   int          exp_n = 0;
   int          chk_from = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic push(input logic [23:0] d, input logic [6:0] s,
                       input bit tb, input bit keep);
      @(negedge clk);
      smp_valid = 1'b1; smp_data = d; smp_status = s;
      @(negedge clk);
      smp_valid = 1'b0;
      if (keep) begin
         exp_w[exp_n] = fmt_long ? {tb, s, d} : {8'h00, d};
         exp_b[exp_n] = fmt_long ? 32 : 24;
         exp_n++;
      end
   endtask

   task automatic drain(input string req);
      int guard = 0;
      while (got_n < exp_n && guard < 5000) begin
         @(negedge clk); guard++;
      end
      repeat (6) @(negedge clk);
      check(got_n == exp_n, req, 32'(got_n), 32'(exp_n));
      for (int i = chk_from; i < exp_n && i < got_n; i++) begin
         check(got_w[i] == exp_w[i], req, got_w[i], exp_w[i]);
         check(got_b[i] == exp_b[i], {req, " R4 bit count"}, 32'(got_b[i]), 32'(exp_b[i]));
         check(got_l[i] == 2 * exp_b[i], {req, " R3 frame length"},
               32'(got_l[i]), 32'(2 * exp_b[i]));
      end
      chk_from = exp_n;
   endtask

   initial begin
      while (cycles < 150000) @(negedge clk);
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10 reset state
      check(!ser_frame && !ser_clk && !ser_dout && !ovf_flag, "R10 reset",
            {28'b0, ser_frame, ser_clk, ser_dout, ovf_flag}, 32'h0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check(got_n == 0, "R10 no frame from empty queue", 32'(got_n), 32'h0);

      // R1 / R2 / R6: sweep of both formats, eight entries each, back to back
      for (int f = 1; f >= 0; f--) begin
         fmt_long = f[0];
         for (int k = 0; k < 8; k++)
            push(24'h5A5A5A ^ (24'h1 << (k * 3)), 7'(k * 17 + f), 1'b0, 1'b1);
         drain(f ? "R1 long frame" : "R2 short frame");
      end

      // R7 overflow: twelve back-to-back samples, nine survive
      fmt_long = 1'b1;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         smp_valid = 1'b1; smp_data = 24'(k * 24'h010203 + 24'h000F00);
         smp_status = 7'(k);
         if (k < 9) begin
            exp_w[exp_n] = {1'b0, 7'(k), 24'(k * 24'h010203 + 24'h000F00)};
            exp_b[exp_n] = 32; exp_n++;
         end
      end
      @(negedge clk); smp_valid = 1'b0;
      check(ovf_flag, "R7 overflow set", {31'b0, ovf_flag}, 32'h1);
      drain("R7 R6 order after drop");
      check(ovf_flag, "R7 overflow sticky", {31'b0, ovf_flag}, 32'h1);
      @(negedge clk); ovf_clear = 1'b1;
      @(negedge clk); ovf_clear = 1'b0;
      check(!ovf_flag, "R7 overflow cleared", {31'b0, ovf_flag}, 32'h0);

      // R8 time break: pulse, then sample carries flag; next one does not
      @(negedge clk); tb_strobe = 1'b1;
      repeat (2) @(negedge clk); tb_strobe = 1'b0;
      repeat (6) @(negedge clk);
      push(24'hABCDEF, 7'h15, 1'b1, 1'b1);
      repeat (3) @(negedge clk);
      push(24'h123456, 7'h2A, 1'b0, 1'b1);
      // R8 held strobe counts once
      @(negedge clk); tb_strobe = 1'b1;
      repeat (8) @(negedge clk);
      push(24'h00FF00, 7'h01, 1'b1, 1'b1);
      repeat (8) @(negedge clk);
      push(24'hFF00FF, 7'h02, 1'b0, 1'b1);
      tb_strobe = 1'b0;
      drain("R8 time-break flag");

      // R9 interleaved writes while frames drain
      for (int k = 0; k < 14; k++) begin
         push(24'(k * 24'h111111), 7'(k + 3), 1'b0, 1'b1);
         repeat (29 + (k % 3)) @(negedge clk);
      end
      drain("R9 write and read together");

      check(gap_bad == 0, "R5 idle gap", 32'(gap_bad), 32'h0);
      check(clk_bad == 0, "R4 bit clock outside frame", 32'(clk_bad), 32'h0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule